// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave serial port that lets a host load and read back a bank of eight 9-bit control registers. These registers set up an image-sensor front end. The host frames each transfer by pulling a load strobe low. It then clocks a 13-bit frame in, most significant bit first. The frame carries a direction flag, a 3-bit register address and 9 data bits. A write frame is applied only after the strobe returns high, and only if all 13 bits arrived. A read frame turns the data line around after the address. The port then drives the stored register value back, one bit per serial clock, changing on the falling edge so the host can sample on the rising edge.

The serial clock, strobe and data input are treated as slow signals sampled by a fast system clock. Every edge is found by comparing two registered samples. The data pin is split into an input, an output and an output-enable, which a pad ring combines into one bidirectional line. Every field of every register is also brought out as a parallel, registered output for the rest of the front end.

Top module: `serial_ctrl_regs`

## Requirements
- R1: After reset the configuration register (address 0) holds 9'h070 and the mux register (address 1) holds 9'h0CF. The three gain registers and the three offset registers hold zero.
- R2: A frame is sampled on rising serial-clock edges while the load strobe is low. It carries the direction bit first (0 = write, 1 = read), then address bits A2, A1, A0, then data D8 down to D0. A write frame updates the addressed register once the strobe returns high.
- R3: The parallel outputs follow the stored registers. The configuration register gives: bit 6 internal clamp, bit 5 three-channel mode, bit 4 correlated sampling, bit 2 power-down, bit 1 wide input range, bit 0 single-byte output. The mux register gives: bit 7 R-G-B order, bit 6 red select, bit 5 green select, bit 4 blue select, bits 3..0 clamp level. Addresses 2, 3 and 4 carry the red, green and blue gains in bits 5..0. Addresses 5, 6 and 7 carry the red, green and blue 9-bit offsets.
- R4: The gain registers keep only D5..D0. D8..D6 are stored and read back as zero whatever was written.
- R5: In a read frame, the falling serial-clock edge after A0 drives D8 of the addressed register onto the data output. Each later falling edge drives the next lower bit down to D0, with the output enable high throughout.
- R6: The output enable drops after the falling edge that follows D0 of a read. It is also low whenever the load strobe is high.
- R7: A frame that ends with fewer than 13 bits changes no register.
- R8: A read frame changes no register, whatever the host drives on the data input during its data phase.
- R9: Setting the power-down bit leaves the contents of every other register unchanged.
- R10: Raising the load strobe in mid-frame clears the bit position. The next frame is decoded from its own first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| sload_n_i | input | 1 | Frame strobe, active low |
| sdata_i | input | 1 | Serial data from the host |
| sdata_o | output | 1 | Serial read data to the host |
| sdata_oe_o | output | 1 | Drive enable for the shared data line |
| clamp_int_o | output | 1 | Internal clamp reference select |
| three_ch_o | output | 1 | Three-channel mode |
| cds_en_o | output | 1 | Correlated double sampling enable |
| pwr_down_o | output | 1 | Power-down request |
| range_2v_o | output | 1 | Wide input range select |
| one_byte_o | output | 1 | Single-byte output mode |
| order_rgb_o | output | 1 | Channel order R-G-B when high, B-G-R when low |
| sel_red_o | output | 1 | Single-channel red select |
| sel_green_o | output | 1 | Single-channel green select |
| sel_blue_o | output | 1 | Single-channel blue select |
| clamp_code_o | output | 4 | Clamp level code |
| gain_red_o | output | 6 | Red gain code |
| gain_green_o | output | 6 | Green gain code |
| gain_blue_o | output | 6 | Blue gain code |
| offs_red_o | output | 9 | Red offset, sign and magnitude |
| offs_green_o | output | 9 | Green offset, sign and magnitude |
| offs_blue_o | output | 9 | Blue offset, sign and magnitude |

## Verification
The hardest situation to reach is a frame cut off partway, whether a write or a read. Such a frame must leave the bank untouched and release the data line, and the frame after it must decode cleanly from bit zero. The stimulus reaches this case through a transfer task that takes a bit count. It sends a ten-bit write and a seven-bit read that stops inside the data phase, then follows each with full frames. A cycle-by-cycle model of the register bank is compared with every parallel output on every clock while the port is idle.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int REG_DW = 9;
  localparam int REG_AW = 3;
  localparam int REG_N  = 1 << REG_AW;
  localparam int GAIN_W = 6;

  localparam int A_CFG    = 0;
  localparam int A_MUX    = 1;
  localparam int A_GAIN_R = 2;
  localparam int A_GAIN_G = 3;
  localparam int A_GAIN_B = 4;
  localparam int A_OFF_R  = 5;
  localparam int A_OFF_G  = 6;
  localparam int A_OFF_B  = 7;

  // configuration field positions
  localparam int CB_CLAMP = 6;
  localparam int CB_3CH   = 5;
  localparam int CB_CDS   = 4;
  localparam int CB_PD    = 2;
  localparam int CB_RANGE = 1;
  localparam int CB_1BYTE = 0;
  // mux field positions
  localparam int MB_ORDER = 7;
  localparam int MB_RED   = 6;
  localparam int MB_GREEN = 5;
  localparam int MB_BLUE  = 4;

  function automatic logic [REG_DW-1:0] reg_default(input int idx);
    case (idx)
      A_CFG:   return 9'h070;
      A_MUX:   return 9'h0CF;
      default: return '0;
    endcase
  endfunction

  function automatic logic [REG_DW-1:0] reg_mask(input int idx);
    if (idx >= A_GAIN_R && idx <= A_GAIN_B)
      return REG_DW'((1 << GAIN_W) - 1);
    return '1;
  endfunction
endpackage

// File: rtl/sctl_frame.sv
module sctl_frame
  import sctl_pkg::*;
#(
  parameter int DATA_W = REG_DW,
  parameter int ADDR_W = REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sload_n_i,
  input  logic              sdata_i,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdata_o,
  output logic              sdata_oe_o
);
  localparam int FLEN = 1 + ADDR_W + DATA_W;
  localparam int CW   = $clog2(FLEN + 1);
  localparam logic [CW-1:0] LAST      = CW'(FLEN);
  localparam logic [CW-1:0] ADDR_DONE = CW'(ADDR_W + 1);

  logic s_sclk, d_sclk, s_ld, d_ld, s_dat;
  logic rise, fall;
  logic [CW-1:0]     cnt;
  logic [FLEN-2:0]   shreg;
  logic              rw_q;
  logic [DATA_W-1:0] rd_sh;
  logic              sdo_q, oe_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_sclk <= 1'b0;
      d_sclk <= 1'b0;
      s_ld   <= 1'b1;
      d_ld   <= 1'b1;
      s_dat  <= 1'b0;
    end else begin
      s_sclk <= sclk_i;
      d_sclk <= s_sclk;
      s_ld   <= sload_n_i;
      d_ld   <= s_ld;
      s_dat  <= sdata_i;
    end
  end

  assign rise = s_sclk & ~d_sclk;
  assign fall = ~s_sclk & d_sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      shreg <= '0;
      rw_q  <= 1'b0;
      rd_sh <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      // commit only on the strobe's rising edge after a complete write frame
      wr_q <= s_ld && !d_ld && (cnt == LAST) && !rw_q;
      if (s_ld) begin
        cnt  <= '0;
        oe_q <= 1'b0;
      end else begin
        if (rise && cnt != LAST) begin
          shreg <= {shreg[FLEN-3:0], s_dat};
          cnt   <= cnt + 1'b1;
          if (cnt == '0) rw_q <= s_dat;
        end
        if (fall && rw_q && cnt >= ADDR_DONE && cnt != LAST) begin
          oe_q <= 1'b1;
          if (cnt == ADDR_DONE) begin
            sdo_q <= rd_data[DATA_W-1];
            rd_sh <= {rd_data[DATA_W-2:0], 1'b0};
          end else begin
            sdo_q <= rd_sh[DATA_W-1];
            rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
          end
        end else if (fall && cnt == LAST) begin
          oe_q <= 1'b0;
        end
      end
    end
  end

  assign rd_addr    = shreg[ADDR_W-1:0];
  assign wr_addr    = shreg[DATA_W +: ADDR_W];
  assign wr_data    = shreg[DATA_W-1:0];
  assign wr_en      = wr_q;
  assign sdata_o    = sdo_q;
  assign sdata_oe_o = oe_q;
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
  import sctl_pkg::*;
#(
  parameter int DATA_W = REG_DW,
  parameter int ADDR_W = REG_AW,
  localparam int NR    = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NR*DATA_W-1:0] bank_o
);
  logic [DATA_W-1:0] bank_q [NR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) bank_q[i] <= DATA_W'(reg_default(i));
    end else if (wr_en) begin
      bank_q[wr_addr] <= wr_data & DATA_W'(reg_mask(int'(wr_addr)));
    end
  end

  assign rd_data = bank_q[rd_addr];

  for (genvar g = 0; g < NR; g++) begin : g_flat
    assign bank_o[g*DATA_W +: DATA_W] = bank_q[g];
  end
endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import sctl_pkg::*;
#(
  parameter int DATA_W = REG_DW,
  parameter int ADDR_W = REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sload_n_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              clamp_int_o,
  output logic              three_ch_o,
  output logic              cds_en_o,
  output logic              pwr_down_o,
  output logic              range_2v_o,
  output logic              one_byte_o,
  output logic              order_rgb_o,
  output logic              sel_red_o,
  output logic              sel_green_o,
  output logic              sel_blue_o,
  output logic [3:0]        clamp_code_o,
  output logic [GAIN_W-1:0] gain_red_o,
  output logic [GAIN_W-1:0] gain_green_o,
  output logic [GAIN_W-1:0] gain_blue_o,
  output logic [DATA_W-1:0] offs_red_o,
  output logic [DATA_W-1:0] offs_green_o,
  output logic [DATA_W-1:0] offs_blue_o
);
  localparam int NR = 1 << ADDR_W;

  logic                 frame_wr;
  logic [ADDR_W-1:0]    wr_addr, rd_addr;
  logic [DATA_W-1:0]    wr_data, rd_data;
  logic [NR*DATA_W-1:0] bank_flat;
  logic [DATA_W-1:0]    cfg, mux, g_r, g_g, g_b;
  logic                 unused_bits;

  sctl_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sload_n_i(sload_n_i), .sdata_i(sdata_i),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(frame_wr), .wr_addr(wr_addr),
    .wr_data(wr_data), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o)
  );

  sctl_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(frame_wr), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bank_o(bank_flat)
  );

  assign cfg = bank_flat[A_CFG*DATA_W    +: DATA_W];
  assign mux = bank_flat[A_MUX*DATA_W    +: DATA_W];
  assign g_r = bank_flat[A_GAIN_R*DATA_W +: DATA_W];
  assign g_g = bank_flat[A_GAIN_G*DATA_W +: DATA_W];
  assign g_b = bank_flat[A_GAIN_B*DATA_W +: DATA_W];

  assign clamp_int_o  = cfg[CB_CLAMP];
  assign three_ch_o   = cfg[CB_3CH];
  assign cds_en_o     = cfg[CB_CDS];
  assign pwr_down_o   = cfg[CB_PD];
  assign range_2v_o   = cfg[CB_RANGE];
  assign one_byte_o   = cfg[CB_1BYTE];
  assign order_rgb_o  = mux[MB_ORDER];
  assign sel_red_o    = mux[MB_RED];
  assign sel_green_o  = mux[MB_GREEN];
  assign sel_blue_o   = mux[MB_BLUE];
  assign clamp_code_o = mux[3:0];
  assign gain_red_o   = g_r[GAIN_W-1:0];
  assign gain_green_o = g_g[GAIN_W-1:0];
  assign gain_blue_o  = g_b[GAIN_W-1:0];
  assign offs_red_o   = bank_flat[A_OFF_R*DATA_W +: DATA_W];
  assign offs_green_o = bank_flat[A_OFF_G*DATA_W +: DATA_W];
  assign offs_blue_o  = bank_flat[A_OFF_B*DATA_W +: DATA_W];

  // reserved bits are stored and readable but drive no field
  assign unused_bits = ^{cfg[DATA_W-1:CB_CLAMP+1], cfg[3], mux[DATA_W-1:MB_ORDER+1],
                         g_r[DATA_W-1:GAIN_W], g_g[DATA_W-1:GAIN_W], g_b[DATA_W-1:GAIN_W]};
endmodule

// File: rtl/sctl_checker.sv
module sctl_checker
  import sctl_pkg::*;
#(
  parameter int BANK_W = REG_N * REG_DW
) (
  input logic              clk,
  input logic              rst,
  input logic              sload_n_i,
  input logic              sdata_oe_o,
  input logic              wr_en,
  input logic [BANK_W-1:0] bank
);
  // R6: line released two cycles after the strobe is seen high
  p_release_idle_r6: assert property (@(posedge clk) disable iff (rst)
    $past(sload_n_i, 2) |-> !sdata_oe_o);

  // R2: the bank changes only right after a strobe rising edge
  p_write_at_end_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(bank) |-> ($past(sload_n_i, 3) && !$past(sload_n_i, 4)));

  // R8: without a write strobe from the frame logic the bank holds
  p_hold_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bank));

  // R7: one frame end gives at most one single-cycle write
  p_single_write_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

bind serial_ctrl_regs sctl_checker u_chk (
  .clk(clk), .rst(rst), .sload_n_i(sload_n_i), .sdata_oe_o(sdata_oe_o),
  .wr_en(frame_wr), .bank(bank_flat)
);

// File: tb/test_serial_ctrl_regs.sv
module test_serial_ctrl_regs;
  localparam int H = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, sclk = 1'b0, sload_n = 1'b1, sdata_in = 1'b0;
  logic sdata_o, sdata_oe_o;
  logic clamp_int_o, three_ch_o, cds_en_o, pwr_down_o, range_2v_o, one_byte_o;
  logic order_rgb_o, sel_red_o, sel_green_o, sel_blue_o;
  logic [3:0] clamp_code_o;
  logic [5:0] gain_red_o, gain_green_o, gain_blue_o;
  logic [8:0] offs_red_o, offs_green_o, offs_blue_o;

  serial_ctrl_regs i_serial_ctrl_regs (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sload_n_i(sload_n), .sdata_i(sdata_in),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
    .clamp_int_o(clamp_int_o), .three_ch_o(three_ch_o), .cds_en_o(cds_en_o),
    .pwr_down_o(pwr_down_o), .range_2v_o(range_2v_o), .one_byte_o(one_byte_o),
    .order_rgb_o(order_rgb_o), .sel_red_o(sel_red_o), .sel_green_o(sel_green_o),
    .sel_blue_o(sel_blue_o), .clamp_code_o(clamp_code_o),
    .gain_red_o(gain_red_o), .gain_green_o(gain_green_o), .gain_blue_o(gain_blue_o),
    .offs_red_o(offs_red_o), .offs_green_o(offs_green_o), .offs_blue_o(offs_blue_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit settled = 1'b0, done = 1'b0;
  logic [8:0] m [8];

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [8:0] mask(input int a);
    return (a >= 2 && a <= 4) ? 9'h03F : 9'h1FF;
  endfunction

  function automatic logic [58:0] fields_exp();
    return {m[0][6], m[0][5], m[0][4], m[0][2], m[0][1], m[0][0],
            m[1][7], m[1][6], m[1][5], m[1][4], m[1][3:0],
            m[2][5:0], m[3][5:0], m[4][5:0], m[5], m[6], m[7]};
  endfunction

  function automatic logic [58:0] fields_got();
    return {clamp_int_o, three_ch_o, cds_en_o, pwr_down_o, range_2v_o, one_byte_o,
            order_rgb_o, sel_red_o, sel_green_o, sel_blue_o, clamp_code_o,
            gain_red_o, gain_green_o, gain_blue_o, offs_red_o, offs_green_o, offs_blue_o};
  endfunction

  // R3: every clock while idle, all field outputs match the model bank
  always @(negedge clk) if (settled && !rst) check("R3 field outputs", fields_got(), fields_exp());

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog (all requirements) got=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic rw, input logic [2:0] a, input logic [8:0] d,
                      input int nbits, output logic [8:0] rd);
    logic [12:0] fr;
    bit oe_ok;
    fr = {rw, a, d};
    rd = '0;
    oe_ok = 1'b1;
    settled = 1'b0;
    sload_n = 1'b0;
    wait_cyc(H);
    for (int k = 0; k < nbits; k++) begin
      sdata_in = fr[12-k];
      wait_cyc(H);
      sclk = 1'b1;
      wait_cyc(H);
      sclk = 1'b0;
      wait_cyc(H);
      if (rw && k >= 3 && k < 12) begin
        rd[11-k] = sdata_o;
        if (!sdata_oe_o) oe_ok = 1'b0;
      end
    end
    if (rw && nbits == 13) begin
      check("R5 enable held through data", oe_ok, 1);
      check("R6 released after D0", sdata_oe_o, 0);
    end
    sload_n = 1'b1;
    sdata_in = 1'b0;
    wait_cyc(H);
    check("R6 released with strobe high", sdata_oe_o, 0);
    if (!rw && nbits == 13) m[a] = d & mask(a);
    wait_cyc(2);
    settled = 1'b1;
  endtask

  logic [8:0] rd;

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 9'h000;
    m[0] = 9'h070;
    m[1] = 9'h0CF;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    settled = 1'b1;

    // R1 reset state at the ports
    check("R1 cfg fields", {clamp_int_o, three_ch_o, cds_en_o, pwr_down_o, range_2v_o, one_byte_o}, 6'b111000);
    check("R1 mux fields", {order_rgb_o, sel_red_o, sel_green_o, sel_blue_o, clamp_code_o}, 8'b1100_1111);
    check("R1 gains zero", {gain_red_o, gain_green_o, gain_blue_o}, 0);
    check("R1 offsets zero", {offs_red_o, offs_green_o, offs_blue_o}, 0);
    check("R6 idle enable", sdata_oe_o, 0);

    // R5 read back reset values
    for (int a = 0; a < 8; a++) begin
      xfer(1'b1, 3'(a), 9'h1FF, 13, rd);
      check("R5 read reset value", rd, m[a]);
    end

    // R2 MSB-first capture
    xfer(1'b0, 3'd5, 9'h101, 13, rd);
    check("R2 bit order offset red", offs_red_o, 9'h101);

    // R2/R4 write every register, then read back
    for (int a = 0; a < 8; a++) xfer(1'b0, 3'(a), 9'h1A5 ^ 9'(a * 37), 13, rd);
    for (int a = 0; a < 8; a++) begin
      xfer(1'b1, 3'(a), 9'h000, 13, rd);
      check("R2 R4 read after write", rd, m[a]);
    end
    xfer(1'b0, 3'd3, 9'h1FF, 13, rd);
    check("R4 gain green masked", gain_green_o, 6'h3F);
    xfer(1'b1, 3'd3, 9'h000, 13, rd);
    check("R4 upper gain bits read zero", rd, 9'h03F);

    // R3 mux field positions
    xfer(1'b0, 3'd1, 9'b0_0010_0101, 13, rd);
    check("R3 mux decode", {order_rgb_o, sel_red_o, sel_green_o, sel_blue_o, clamp_code_o}, 8'b0010_0101);
    xfer(1'b0, 3'd0, 9'b0_0000_0011, 13, rd);
    check("R3 cfg decode", {clamp_int_o, three_ch_o, cds_en_o, pwr_down_o, range_2v_o, one_byte_o}, 6'b000011);

    // R9 power-down keeps the rest
    xfer(1'b0, 3'd0, 9'h004, 13, rd);
    check("R9 power-down set", pwr_down_o, 1);
    xfer(1'b1, 3'd7, 9'h000, 13, rd);
    check("R9 offset blue retained", rd, m[7]);
    check("R9 gain red retained", gain_red_o, m[2][5:0]);

    // R7 short write discarded
    xfer(1'b0, 3'd6, 9'h0AA, 10, rd);
    check("R7 short frame ignored", offs_green_o, m[6]);

    // R8 read with busy data input leaves bank alone
    xfer(1'b1, 3'd6, 9'h155, 13, rd);
    check("R8 read value", rd, m[6]);
    check("R8 offset green unchanged", offs_green_o, m[6]);

    // R6/R10 aborted read, then a clean write
    xfer(1'b1, 3'd2, 9'h000, 7, rd);
    xfer(1'b0, 3'd4, 9'h02B, 13, rd);
    check("R10 write after abort", gain_blue_o, 6'h2B);
    xfer(1'b1, 3'd4, 9'h000, 13, rd);
    check("R10 read after abort", rd, 9'h02B);

    wait_cyc(5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule